// File: doc/BRIEF.md
# SPI Master Frame Timer

This block produces the chip-select and serial-clock waveform of an SPI master frame, counted in system clocks. A frame begins when a start request is seen while the block is idle. Chip-select falls and a lead interval runs. The block then emits the requested number of SCK cycles. Chip-select rises after the last low phase, and a trailing idle gap follows before another frame may begin. A strobe marks every SCK transition, so a separate shifter can move data on it. A one-cycle flag marks the end of each frame.

Each interval is an odd prescaler times a power-of-two scaler. The lead, baud and gap intervals each take a 2-bit prescaler code and a 4-bit scaler code. All configuration codes and the bit count are captured when chip-select falls. The frame, including its trailing gap, runs on those captured values. A request that arrives before the gap has elapsed is dropped. A request held high through the gap starts the next frame the moment the gap ends.

Top module: `spi_frame_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes idle: `cs_n_o`=1, `sck_o`=0, `edge_o`=0 and `done_o`=0.
- R2: When `start_i` is high at a clock edge while idle, `cs_n_o` goes low at that same edge.
- R3: The first SCK rising edge comes exactly Plead*Slead clocks after `cs_n_o` falls. Prescaler codes 0,1,2,3 give 1,3,5,7. Scaler code n gives 2^(n+1), and codes 13, 14 and 15 all give 16384.
- R4: The SCK period is Pbaud*Sbaud clocks. Baud prescaler codes 0,1,2,3 give 2,3,5,7, and the scaler uses the R3 encoding. `sck_o` idles low and starts with a rising edge. The high phase lasts floor(period/2) clocks and the low phase lasts the remainder.
- R5: A frame of N bits makes exactly 2N SCK transitions. `edge_o` is high in exactly the cycles in which `sck_o` holds a new value. A bit count of 0 is treated as 1.
- R6: `cs_n_o` rises one full low phase after the final falling SCK edge. `done_o` is high for that single cycle only.
- R7: `cs_n_o` stays high for at least Pgap*Sgap clocks after a frame. Gap prescaler codes 0,1,2,3 give 1,3,5,7, and the scaler uses the R3 encoding. If `start_i` is high when the gap ends, `cs_n_o` falls at once, so the high time is exactly Pgap*Sgap.
- R8: A `start_i` pulse while `cs_n_o` is low, or during the trailing gap before its last cycle, starts no frame.
- R9: Changes to any configuration input or to `nbits_i` after `cs_n_o` falls do not affect the current frame or its trailing gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame request (level, sampled each clock) |
| nbits_i | input | NB_W | Bits per frame, 0 means 1 |
| baud_pre_i | input | 2 | Baud prescaler code |
| baud_scl_i | input | 4 | Baud scaler code |
| lead_pre_i | input | 2 | Select-to-clock prescaler code |
| lead_scl_i | input | 4 | Select-to-clock scaler code |
| gap_pre_i | input | 2 | After-transfer gap prescaler code |
| gap_scl_i | input | 4 | After-transfer gap scaler code |
| cs_n_o | output | 1 | Chip-select, active low |
| sck_o | output | 1 | Serial clock |
| edge_o | output | 1 | High in the cycle SCK changes |
| done_o | output | 1 | One-cycle pulse at the end of a frame |

## Verification
A wrong internal state shows within one SCK phase. A miscounted span counter moves an SCK edge, or the chip-select rise, by at least one cycle. A bad transition count adds or drops a whole phase before `done_o`. A stale or early capture of the configuration shows as a wrong lead length at the first rising edge, or as wrong phase lengths on the first phase that uses it. The bench builds the expected waveform of each frame from the formulas and compares all four outputs on every clock, so such a fault is reported in the first cycle it reaches a port.

// File: rtl/spi_tm_pkg.sv
package spi_tm_pkg;

    localparam int PRE_W       = 2;
    localparam int SCL_W       = 4;
    localparam int SCL_MAX_EXP = 14;
    localparam int DLY_W       = SCL_MAX_EXP + 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_GAP
    } tm_state_e;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [SCL_W-1:0] scl;
    } dly_code_t;

    typedef struct packed {
        dly_code_t baud;
        dly_code_t lead;
        dly_code_t gap;
    } tm_cfg_t;

    // Odd prescaler. The baud variant starts at 2 instead of 1.
    function automatic logic [DLY_W-1:0] pre_value(input logic [PRE_W-1:0] code,
                                                   input logic is_baud);
        logic [DLY_W-1:0] v;
        unique case (code)
            2'd0:    v = is_baud ? DLY_W'(2) : DLY_W'(1);
            2'd1:    v = DLY_W'(3);
            2'd2:    v = DLY_W'(5);
            default: v = DLY_W'(7);
        endcase
        return v;
    endfunction

    // Power-of-two exponent: code n gives n+1, saturating at SCL_MAX_EXP.
    function automatic int unsigned scl_exp(input logic [SCL_W-1:0] code);
        int unsigned e;
        e = int'(code) + 1;
        if (e > SCL_MAX_EXP) e = SCL_MAX_EXP;
        return e;
    endfunction

endpackage

// File: rtl/spi_tm_delay_calc.sv
module spi_tm_delay_calc
    import spi_tm_pkg::*;
#(
    parameter bit IS_BAUD = 1'b0
) (
    input  dly_code_t        code_i,
    output logic [DLY_W-1:0] cycles_o
);

    always_comb begin
        cycles_o = pre_value(code_i.pre, IS_BAUD) << scl_exp(code_i.scl);
    end

endmodule

// File: rtl/spi_tm_span_counter.sv
module spi_tm_span_counter #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] len_i,
    output logic         last_o
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last_o = en && (cnt == len_i - 1'b1);

    // R3/R4/R7: a running span never passes its programmed length
    a_r3_span_within_len: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt < len_i));

endmodule

// File: rtl/spi_frame_timer.sv
module spi_frame_timer
    import spi_tm_pkg::*;
#(
    parameter int NB_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [NB_W-1:0] nbits_i,
    input  logic [1:0]      baud_pre_i,
    input  logic [3:0]      baud_scl_i,
    input  logic [1:0]      lead_pre_i,
    input  logic [3:0]      lead_scl_i,
    input  logic [1:0]      gap_pre_i,
    input  logic [3:0]      gap_scl_i,
    output logic            cs_n_o,
    output logic            sck_o,
    output logic            edge_o,
    output logic            done_o
);

    localparam int EDG_W    = NB_W + 1;
    localparam int N_SPANS  = 3;
    localparam int IX_BAUD  = 0;
    localparam int IX_LEAD  = 1;
    localparam int IX_GAP   = 2;

    tm_state_e        state;
    tm_cfg_t          cfg_in, cfg_q;
    logic [NB_W-1:0]  bits_q;
    logic [EDG_W-1:0] edges_q, edges_total;
    logic             cs_n_q, sck_q, edge_q, done_q;

    dly_code_t        code_sel   [N_SPANS];
    logic [DLY_W-1:0] span_cycles[N_SPANS];
    logic [DLY_W-1:0] half_hi, half_lo, span_len;
    logic             span_last, span_clr, span_en, take;

    // Configuration as seen on the pins
    always_comb begin
        cfg_in.baud.pre = baud_pre_i;
        cfg_in.baud.scl = baud_scl_i;
        cfg_in.lead.pre = lead_pre_i;
        cfg_in.lead.scl = lead_scl_i;
        cfg_in.gap.pre  = gap_pre_i;
        cfg_in.gap.scl  = gap_scl_i;
    end

    assign code_sel[IX_BAUD] = cfg_q.baud;
    assign code_sel[IX_LEAD] = cfg_q.lead;
    assign code_sel[IX_GAP]  = cfg_q.gap;

    for (genvar g = 0; g < N_SPANS; g++) begin : g_calc
        spi_tm_delay_calc #(
            .IS_BAUD(g == IX_BAUD)
        ) u_calc (
            .code_i  (code_sel[g]),
            .cycles_o(span_cycles[g])
        );
    end

    assign half_hi     = span_cycles[IX_BAUD] >> 1;
    assign half_lo     = span_cycles[IX_BAUD] - half_hi;
    assign edges_total = {bits_q, 1'b0};

    always_comb begin
        unique case (state)
            ST_LEAD:  span_len = span_cycles[IX_LEAD];
            ST_SHIFT: span_len = sck_q ? half_hi : half_lo;
            ST_GAP:   span_len = span_cycles[IX_GAP];
            default:  span_len = span_cycles[IX_LEAD];
        endcase
    end

    assign span_en  = (state != ST_IDLE);
    assign span_clr = (state == ST_IDLE) || span_last;

    spi_tm_span_counter #(
        .W(DLY_W)
    ) u_span (
        .clk   (clk),
        .rst   (rst),
        .clr   (span_clr),
        .en    (span_en),
        .len_i (span_len),
        .last_o(span_last)
    );

    // A request is taken when idle, or on the final cycle of the gap
    assign take = start_i && ((state == ST_IDLE) || ((state == ST_GAP) && span_last));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cs_n_q  <= 1'b1;
            sck_q   <= 1'b0;
            edge_q  <= 1'b0;
            done_q  <= 1'b0;
            cfg_q   <= '0;
            bits_q  <= '0;
            edges_q <= '0;
        end else begin
            edge_q <= 1'b0;
            done_q <= 1'b0;
            if (take) begin
                state   <= ST_LEAD;
                cs_n_q  <= 1'b0;
                cfg_q   <= cfg_in;
                bits_q  <= (nbits_i == '0) ? NB_W'(1) : nbits_i;
                edges_q <= '0;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_LEAD: begin
                        if (span_last) begin
                            state   <= ST_SHIFT;
                            sck_q   <= 1'b1;
                            edge_q  <= 1'b1;
                            edges_q <= EDG_W'(1);
                        end
                    end
                    ST_SHIFT: begin
                        if (span_last) begin
                            if (edges_q == edges_total) begin
                                state  <= ST_GAP;
                                cs_n_q <= 1'b1;
                                done_q <= 1'b1;
                            end else begin
                                sck_q   <= ~sck_q;
                                edge_q  <= 1'b1;
                                edges_q <= edges_q + 1'b1;
                            end
                        end
                    end
                    ST_GAP: begin
                        if (span_last) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign cs_n_o = cs_n_q;
    assign sck_o  = sck_q;
    assign edge_o = edge_q;
    assign done_o = done_q;

    // R4: SCK rests low outside a frame
    a_r4_sck_low_when_deselected: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> !sck_o);

    // R5: strobes only inside a frame, and only when SCK took a new value
    a_r5_edge_inside_frame: assert property (@(posedge clk) disable iff (rst)
        edge_o |-> !cs_n_o);
    a_r5_edge_marks_toggle: assert property (@(posedge clk) disable iff (rst)
        edge_o |-> (sck_o != $past(sck_o)));

    // R6: done accompanies the chip-select rise
    a_r6_done_with_cs_rise: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $rose(cs_n_o));

    // R3: the lead interval is never zero, so no SCK edge at select assertion
    a_r3_no_edge_at_select: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_o) |-> (!edge_o && !sck_o));

    // R8: chip-select cannot return low before the gap has run out
    a_r8_gap_holds_select_high: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP && !span_last) |=> cs_n_o);

endmodule

// File: tb/sim_spi_frame_timer.sv
module sim_spi_frame_timer;

    localparam int NB_W = 6;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [NB_W-1:0] nbits = '0;
    logic [1:0]      bpre = '0, lpre = '0, gpre = '0;
    logic [3:0]      bscl = '0, lscl = '0, gscl = '0;
    logic            cs_n, sck, edg, done;

    always #10 clk = ~clk;

    spi_frame_timer #(.NB_W(NB_W)) u0 (
        .clk(clk), .rst(rst), .start_i(start), .nbits_i(nbits),
        .baud_pre_i(bpre), .baud_scl_i(bscl),
        .lead_pre_i(lpre), .lead_scl_i(lscl),
        .gap_pre_i(gpre), .gap_scl_i(gscl),
        .cs_n_o(cs_n), .sck_o(sck), .edge_o(edg), .done_o(done)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    int frames_started = 0, done_cnt = 0;
    int exp_lead = 0, exp_n = 0;
    int lead_cnt = 0, edge_cnt = 0;
    bit in_shift = 0, finished = 0;
    logic [3:0] q[$];
    logic [3:0] exp_now = 4'b1000;   // {cs_n, sck, edge, done}

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
        end
    endtask

    function automatic int pre_of(input int code, input bit baud);
        int tbl[4] = '{1, 3, 5, 7};
        if (baud && code == 0) return 2;
        return tbl[code];
    endfunction

    function automatic int scl_of(input int code);
        return (code >= 13) ? 16384 : (1 << (code + 1));
    endfunction

    // Expected samples of one whole frame, from the formulas
    task automatic build_frame();
        int p, hi, lo, lead, gap, n, len;
        bit v;
        p    = pre_of(int'(bpre), 1) * scl_of(int'(bscl));
        hi   = p / 2;
        lo   = p - hi;
        lead = pre_of(int'(lpre), 0) * scl_of(int'(lscl));
        gap  = pre_of(int'(gpre), 0) * scl_of(int'(gscl));
        n    = (nbits == 0) ? 1 : int'(nbits);
        for (int k = 0; k < lead; k++) q.push_back(4'b0000);
        for (int j = 1; j <= 2 * n; j++) begin
            v   = (j % 2) == 1;
            len = v ? hi : lo;
            for (int k = 0; k < len; k++) q.push_back({1'b0, v, (k == 0), 1'b0});
        end
        for (int k = 0; k < gap; k++) q.push_back({1'b1, 1'b0, 1'b0, (k == 0)});
        exp_lead = lead;
        exp_n    = n;
        frames_started++;
    endtask

    // Reference model: one expected sample per clock
    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            exp_now = 4'b1000;
        end else begin
            if (q.size() == 0 && start) build_frame();
            if (q.size() > 0) exp_now = q.pop_front();
            else exp_now = 4'b1000;
        end
    end

    // Per-clock comparison and interval monitors
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check({cs_n, sck, edg, done} == exp_now,
                  "R2/R4/R5/R6/R7/R8/R9 {cs_n,sck,edge,done}",
                  longint'({cs_n, sck, edg, done}), longint'(exp_now));
            if (done) done_cnt++;
            if (!cs_n && !in_shift) begin
                if (edg) begin
                    check(lead_cnt == exp_lead, "R3 select-to-first-edge clocks", lead_cnt, exp_lead);
                    in_shift = 1;
                    edge_cnt = 1;
                end else begin
                    lead_cnt++;
                end
            end else if (!cs_n && edg) begin
                edge_cnt++;
            end
            if (done) begin
                check(edge_cnt == 2 * exp_n, "R5 SCK transitions per frame", edge_cnt, 2 * exp_n);
                in_shift = 0;
                lead_cnt = 0;
            end
        end
    end

    task automatic finish_run();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic set_cfg(input int bp, input int bs, input int lp, input int ls,
                           input int gp, input int gs, input int n);
        bpre = 2'(bp); bscl = 4'(bs); lpre = 2'(lp); lscl = 4'(ls);
        gpre = 2'(gp); gscl = 4'(gs); nbits = NB_W'(n);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (q.size() != 0 || !cs_n) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int d0, f0;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
        check(sck == 1'b0, "R1 sck in reset", sck, 0);
        check(edg == 1'b0, "R1 edge in reset", edg, 0);
        check(done == 1'b0, "R1 done in reset", done, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R2, R3, R4, R6: smallest settings, three bits
        set_cfg(0, 0, 0, 0, 0, 0, 3);
        d0 = done_cnt;
        pulse_start();
        wait_idle();
        check(done_cnt == d0 + 1, "R2 single request one frame", done_cnt - d0, 1);

        // R4, R7: odd prescalers, start held for three back-to-back frames
        set_cfg(1, 1, 2, 1, 3, 0, 2);
        f0 = frames_started;
        @(negedge clk) start = 1'b1;
        while (frames_started < f0 + 3) @(negedge clk);
        start = 1'b0;
        wait_idle();
        check(frames_started == f0 + 3, "R7 back-to-back frames", frames_started - f0, 3);

        // R5: bit count zero is one bit
        set_cfg(2, 0, 1, 0, 0, 1, 0);
        pulse_start();
        wait_idle();

        // R8: requests during the frame and the gap are dropped
        set_cfg(0, 1, 0, 2, 3, 2, 4);
        d0 = done_cnt;
        pulse_start();
        while (q.size() > 3) begin
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
            repeat (5) @(negedge clk);
        end
        wait_idle();
        check(done_cnt == d0 + 1, "R8 requests while busy ignored", done_cnt - d0, 1);

        // R9: inputs change right after select assertion
        set_cfg(1, 0, 0, 3, 1, 1, 5);
        pulse_start();
        repeat (2) @(negedge clk);
        set_cfg(3, 3, 3, 4, 3, 5, 9);
        wait_idle();

        // R3: saturating scaler codes, and prescaler 3 with code 15
        set_cfg(0, 0, 1, 15, 0, 14, 1);
        pulse_start();
        wait_idle();
        set_cfg(0, 0, 0, 13, 0, 0, 1);
        pulse_start();
        wait_idle();

        finish_run();
    end

endmodule